// File: doc/BRIEF.md
# DMA Read Command and Byte-Enable Generator

This block serves the read side of a 32-bit PCI bus master. A DMA engine hands it one read request at a time: a starting byte address, a length in bytes and the current cacheline size in dwords. The block picks the PCI read command for the burst: Memory Read, Memory Read Line or Memory Read Multiple. It then emits one byte-enable mask for every data phase of the burst. The masks leave over a valid/ready stream. The command code is held steady for the whole burst.

Two configuration inputs are sampled when a request is accepted. One forces plain Memory Read on every burst. The other trims the first and last data phases to the bytes the request actually covers; with it clear, every phase enables all four lanes. Masks are active-high, and bit n of a mask covers byte lane n. Conversion to the bus polarity happens outside this block. A request of length zero is accepted, flagged as an error and produces no data phases.

Top module: `dma_rd_cmd_gen`

## Requirements
- R1: With cfg_force_mr_i set at acceptance, cmd_o is Memory Read (4'b0110) for the whole burst, whatever the length or alignment.
- R2: With the force bit clear, a request of 1 to 4 bytes uses Memory Read (4'b0110), even when it spans two dwords.
- R3: With the force bit clear, a request of more than 4 bytes whose last byte lies in the same cacheline as its first byte uses Memory Read Line (4'b1110). The cacheline is req_cl_dw_i*4 bytes and is aligned to its own size.
- R4: With the force bit clear, a request of more than 4 bytes whose last byte lies in a later cacheline than its first byte uses Memory Read Multiple (4'b1100).
- R5: With exact enables on, the first phase enables lanes from addr[1:0] upward. The last phase enables lanes up to (addr+len-1)[1:0]. Every phase in between enables all four lanes (4'hF).
- R6: A request that starts and ends in one dword gives a single phase. Its mask is the AND of the leading and trailing masks.
- R7: With exact enables off at acceptance, every phase carries 4'hF.
- R8: The number of phases equals the number of dwords the request touches. be_last_o is high on the final phase only. After it, be_valid_o drops and req_ready_o returns high.
- R9: A zero-length request raises err_o for exactly the one cycle after acceptance and produces no phase.
- R10: req_ready_o is high only while no burst is in progress. While be_valid_o is high and be_ready_i is low, be_o, be_last_o and cmd_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_force_mr_i | input | 1 | Force Memory Read on every burst |
| cfg_exact_be_i | input | 1 | Trim first and last phase enables to address and size |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be accepted |
| req_addr_i | input | AW (32) | Starting byte address |
| req_len_i | input | LW (12) | Length in bytes |
| req_cl_dw_i | input | CLW (6) | Cacheline size in dwords, a power of two from 4 to 32 |
| cmd_o | output | 4 | PCI read command code, valid with be_valid_o |
| err_o | output | 1 | One-cycle flag for a zero-length request |
| be_valid_o | output | 1 | Data phase mask valid |
| be_ready_i | input | 1 | Consumer takes the current mask |
| be_o | output | 4 | Active-high byte enables; bit n is lane n |
| be_last_o | output | 1 | Current phase is the last of the burst |

## Verification
The leading and trailing trims can land on the same data phase. This happens when a request starts and ends inside one dword. It is provoked with one- and two-byte reads at odd lane offsets, and the single mask is judged against a per-byte coverage model in the bench. The same coincidence arises for the final phase of a burst and consumer back-pressure. It is provoked by holding be_ready_i low on a phase and checking that mask, last flag and command stay put until the handshake. Small requests that straddle a dword or cacheline edge also exercise the size rule and the crossing rule together. There the size rule must win.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
  typedef enum logic [3:0] {
    CMD_MEM_RD      = 4'b0110,
    CMD_MEM_RD_MULT = 4'b1100,
    CMD_MEM_RD_LINE = 4'b1110
  } pci_rd_cmd_e;
endpackage

// File: rtl/dma_rd_cmd_sel.sv
module dma_rd_cmd_sel
  import dma_rd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 12,
  parameter int CLW = 6
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [LW-1:0]  len_i,
  input  logic [CLW-1:0] cl_dw_i,
  input  logic           force_mr_i,
  output pci_rd_cmd_e    cmd_o,
  output logic [AW-1:0]  last_addr_o
);
  logic [AW-1:0] cl_bytes, cl_mask;
  logic          crosses;

  assign last_addr_o = addr_i + AW'(len_i) - AW'(1);
  assign cl_bytes    = AW'(cl_dw_i) << 2;
  assign cl_mask     = ~(cl_bytes - AW'(1));
  // line index of first and last byte differ
  assign crosses     = |((addr_i ^ last_addr_o) & cl_mask);

  always_comb begin
    if (force_mr_i || len_i <= LW'(4)) cmd_o = CMD_MEM_RD;
    else if (crosses)                  cmd_o = CMD_MEM_RD_MULT;
    else                               cmd_o = CMD_MEM_RD_LINE;
  end
endmodule

// File: rtl/dma_rd_be_calc.sv
module dma_rd_be_calc (
  input  logic [1:0] lo_i,
  input  logic [1:0] hi_i,
  input  logic       first_i,
  input  logic       last_i,
  input  logic       exact_i,
  output logic [3:0] be_o
);
  logic [3:0] lead, trail;

  assign lead  = 4'b1111 << lo_i;
  assign trail = 4'b1111 >> (2'd3 - hi_i);

  always_comb begin
    be_o = 4'b1111;
    if (exact_i) begin
      if (first_i) be_o = be_o & lead;
      if (last_i)  be_o = be_o & trail;
    end
  end
endmodule

// File: rtl/dma_rd_phase_seq.sv
module dma_rd_phase_seq #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] nph_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          first_o,
  output logic          last_o
);
  logic [CW-1:0] rem_q;
  logic          valid_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
    end else if (start_i) begin
      rem_q   <= nph_i;
      valid_q <= 1'b1;
      first_q <= 1'b1;
    end else if (valid_q && ready_i) begin
      rem_q   <= rem_q - CW'(1);
      first_q <= 1'b0;
      if (rem_q == CW'(1)) valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign first_o = first_q;
  assign last_o  = valid_q && (rem_q == CW'(1));
endmodule

// File: rtl/dma_rd_cmd_gen.sv
module dma_rd_cmd_gen
  import dma_rd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 12,
  parameter int CLW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_force_mr_i,
  input  logic           cfg_exact_be_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [LW-1:0]  req_len_i,
  input  logic [CLW-1:0] req_cl_dw_i,
  output logic [3:0]     cmd_o,
  output logic           err_o,
  output logic           be_valid_o,
  input  logic           be_ready_i,
  output logic [3:0]     be_o,
  output logic           be_last_o
);
  localparam int CW = LW + 1;

  pci_rd_cmd_e   cmd_nxt, cmd_q;
  logic [AW-1:0] last_addr;
  logic [AW-3:0] dw_span;
  logic [CW-1:0] nph;
  logic          accept, zero_len, start;
  logic [1:0]    lo_q, hi_q;
  logic          exact_q, err_q;
  logic          ph_first;

  assign accept   = req_valid_i && req_ready_o;
  assign zero_len = (req_len_i == '0);
  assign start    = accept && !zero_len;
  assign dw_span  = last_addr[AW-1:2] - req_addr_i[AW-1:2];
  assign nph      = CW'(dw_span) + CW'(1);

  dma_rd_cmd_sel #(.AW(AW), .LW(LW), .CLW(CLW)) u_cmd_sel (
    .addr_i      (req_addr_i),
    .len_i       (req_len_i),
    .cl_dw_i     (req_cl_dw_i),
    .force_mr_i  (cfg_force_mr_i),
    .cmd_o       (cmd_nxt),
    .last_addr_o (last_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_MEM_RD;
      lo_q    <= '0;
      hi_q    <= '0;
      exact_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && zero_len;
      if (start) begin
        cmd_q   <= cmd_nxt;
        lo_q    <= req_addr_i[1:0];
        hi_q    <= last_addr[1:0];
        exact_q <= cfg_exact_be_i;
      end
    end
  end

  dma_rd_phase_seq #(.CW(CW)) u_phase_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .nph_i   (nph),
    .ready_i (be_ready_i),
    .valid_o (be_valid_o),
    .first_o (ph_first),
    .last_o  (be_last_o)
  );

  dma_rd_be_calc u_be_calc (
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .first_i (ph_first),
    .last_i  (be_last_o),
    .exact_i (exact_q),
    .be_o    (be_o)
  );

  assign req_ready_o = !be_valid_o;
  assign cmd_o       = cmd_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dma_rd_cmd_gen_chk.sv
module dma_rd_cmd_gen_chk #(
  parameter int AW  = 32,
  parameter int LW  = 12,
  parameter int CLW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_force_mr_i,
  input logic           cfg_exact_be_i,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [AW-1:0]  req_addr_i,
  input logic [LW-1:0]  req_len_i,
  input logic [CLW-1:0] req_cl_dw_i,
  input logic [3:0]     cmd_o,
  input logic           err_o,
  input logic           be_valid_o,
  input logic           be_ready_i,
  input logic [3:0]     be_o,
  input logic           be_last_o
);
  logic in_burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       in_burst_q <= 1'b0;
    else if (be_valid_o && be_ready_i) in_burst_q <= !be_last_o;
  end

  AST_START_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_len_i != '0 |=> be_valid_o && !req_ready_o); // R10
  AST_ZERO_LEN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_len_i == '0 |=> err_o && !be_valid_o); // R9
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_valid_o && !be_ready_i |=> be_valid_o && $stable(be_o) && $stable(be_last_o) && $stable(cmd_o)); // R10
  AST_MID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_valid_o && in_burst_q && !be_last_o |-> be_o == 4'hF); // R5
  AST_BE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_valid_o |-> be_o != 4'h0); // R6
  AST_CMD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_valid_o |-> cmd_o == 4'b0110 || cmd_o == 4'b1110 || cmd_o == 4'b1100); // R1
endmodule

bind dma_rd_cmd_gen dma_rd_cmd_gen_chk #(.AW(AW), .LW(LW), .CLW(CLW)) u_chk (.*);

// File: tb/dma_rd_cmd_gen_tb.sv
`timescale 1ns/1ps
module dma_rd_cmd_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        force_mr = 1'b0, exact = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic [5:0]  req_cl = 6'd8;
  logic [3:0]  cmd, be;
  logic        err, be_valid, be_ready = 1'b0, be_last;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_rd_cmd_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_force_mr_i(force_mr), .cfg_exact_be_i(exact),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_cl_dw_i(req_cl), .cmd_o(cmd), .err_o(err),
    .be_valid_o(be_valid), .be_ready_i(be_ready), .be_o(be), .be_last_o(be_last));

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // r_tag names the requirement under test; expectations come from per-byte coverage
  task automatic run_req(input logic [31:0] a, input logic [11:0] l, input logic [5:0] cl,
                         input logic frc, input logic ex, input logic stall, input string r_tag);
    logic [31:0] e = a + 32'(l) - 1;
    logic [31:0] clb = 32'(cl) * 4;
    int nph = int'((e >> 2) - (a >> 2)) + 1;
    logic [3:0] exp_cmd;
    if (frc || l <= 4) exp_cmd = 4'b0110;
    else if ((a / clb) != (e / clb)) exp_cmd = 4'b1100;
    else exp_cmd = 4'b1110;
    @(negedge clk);
    req_addr = a; req_len = l; req_cl = cl; force_mr = frc; exact = ex; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; force_mr = ~frc; exact = ~ex;  // config changes after acceptance must not matter
    for (int ph = 0; ph < nph; ph++) begin
      logic [3:0] m = 4'h0;
      logic [31:0] d = (a >> 2) + 32'(ph);
      for (int b = 0; b < 4; b++) begin
        logic [31:0] ba = d * 4 + 32'(b);
        if (!ex || (ba >= a && ba <= e)) m[b] = 1'b1;
      end
      chk(r_tag, "be_valid", 32'(be_valid), 1);
      chk(r_tag, "be", 32'(be), 32'(m));
      chk(r_tag, "be_last", 32'(be_last), 32'(ph == nph - 1));
      chk(r_tag, "cmd", 32'(cmd), 32'(exp_cmd));
      chk("R10", "req_ready busy", 32'(req_ready), 0);
      if (stall) begin
        be_ready = 1'b0;
        @(negedge clk);
        chk("R10", "be held", 32'(be), 32'(m));
        chk("R10", "last held", 32'(be_last), 32'(ph == nph - 1));
        chk("R10", "cmd held", 32'(cmd), 32'(exp_cmd));
      end
      be_ready = 1'b1;
      @(negedge clk);
      be_ready = 1'b0;
    end
    chk("R8", "be_valid after last", 32'(be_valid), 0);
    chk("R8", "req_ready after last", 32'(req_ready), 1);
  endtask

  task automatic run_zero();
    @(negedge clk);
    req_addr = 32'h200; req_len = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "err_o", 32'(err), 1);
    chk("R9", "no phase", 32'(be_valid), 0);
    chk("R9", "still ready", 32'(req_ready), 1);
    @(negedge clk);
    chk("R9", "err_o one cycle", 32'(err), 0);
    chk("R9", "no phase later", 32'(be_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset req_ready", 32'(req_ready), 1);
    chk("R10", "reset be_valid", 32'(be_valid), 0);
    chk("R9", "reset err", 32'(err), 0);
    rst_n = 1'b1;
    run_req(32'h100, 12'd4,  6'd8,  1'b0, 1'b1, 1'b0, "R2");
    run_req(32'h0FE, 12'd4,  6'd8,  1'b0, 1'b1, 1'b0, "R2");
    run_req(32'h101, 12'd2,  6'd8,  1'b0, 1'b1, 1'b0, "R6");
    run_req(32'h103, 12'd1,  6'd8,  1'b0, 1'b1, 1'b1, "R6");
    run_req(32'h102, 12'd20, 6'd8,  1'b0, 1'b1, 1'b0, "R3");
    run_req(32'h102, 12'd20, 6'd8,  1'b0, 1'b1, 1'b1, "R5");
    run_req(32'h11A, 12'd12, 6'd8,  1'b0, 1'b1, 1'b1, "R4");
    run_req(32'h0FF, 12'd5,  6'd8,  1'b0, 1'b1, 1'b0, "R4");
    run_req(32'h10C, 12'd8,  6'd4,  1'b0, 1'b1, 1'b0, "R4");
    run_req(32'h10C, 12'd8,  6'd32, 1'b0, 1'b1, 1'b0, "R3");
    run_req(32'h11A, 12'd12, 6'd8,  1'b1, 1'b1, 1'b0, "R1");
    run_req(32'h103, 12'd6,  6'd8,  1'b0, 1'b0, 1'b1, "R7");
    run_req(32'h101, 12'd2,  6'd8,  1'b0, 1'b0, 1'b0, "R7");
    run_zero();
    run_req(32'h204, 12'd8,  6'd8,  1'b0, 1'b1, 1'b0, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule